// File: doc/BRIEF.md
# Clock-Synchronous Strobe-Bus Register Slave

This block lets an 8-bit host with chip-select and data-strobe signalling read and write a small register bank. All host strobes are sampled on the rising edge of one clock. An access begins when chip select and data strobe are both seen low. The block then waits a fixed number of cycles, which depends on the direction and the address, and pulls its active-low acknowledge low. For a write, the bank receives a single write strobe. For a read, the data bus is driven.

The acknowledge stays low until the host lets chip select go high. This holds even when data strobe and the read/write select stay at their active levels, so a host can run a series of reads or writes by toggling chip select alone. If chip select rises before the acknowledge has been given, the access is dropped without touching the bank.

Top module: `ubus_slave`

## Requirements
- R1: While rst_ni is low, dtack_no is high, data_oe_o is low and no register is written. All bank registers reset to 0x00.
- R2: A read (rw_i = 1) of any address other than 0 drives dtack_no low on the second rising edge after the start edge. The start edge is the edge at which cs_ni and ds_ni are both sampled low in idle.
- R3: A read of address 0 drives dtack_no low on the third rising edge after the start edge.
- R4: A write (rw_i = 0) to any address drives dtack_no low on the third rising edge after the start edge. Each write produces exactly one single-cycle write strobe, on that same edge.
- R5: Once low, dtack_no stays low while cs_ni is sampled low. It returns high on the first edge at which cs_ni is sampled high, even if ds_ni and rw_i are still active.
- R6: With ds_ni and rw_i held at their active levels, toggling cs_ni alone frames consecutive accesses. Each framed access acknowledges and transfers independently.
- R7: If cs_ni is sampled high before dtack_no has gone low, the access is abandoned. dtack_no stays high, the target register is unchanged and the block returns to idle.
- R8: During a read, data_oe_o is high and data_o holds the addressed register from the edge that lowers dtack_no onward. data_oe_o drops on the edge at which cs_ni is sampled high.
- R9: After an access completes, a new access starts on the very next edge at which cs_ni and ds_ni are sampled low.
- R10: The address and write data are captured at the start edge. Changes to data_i after that edge do not alter the value stored.
- R11: A value written to an address is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all inputs sampled on rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low; frames each access |
| ds_ni | input | 1 | Data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 3 | Register address |
| data_i | input | 8 | Write data from host |
| data_o | output | 8 | Read data to host |
| data_oe_o | output | 1 | High while the block drives the data bus |
| dtack_no | output | 1 | Transfer acknowledge, active low |

## Verification
The assertions assume the host changes its strobes, address and data only between clock edges. They also assume it keeps address, direction and write data steady from the start edge, except where a test deliberately changes data_i to show that the captured copy is used. The bench drives every input on the falling edge and never raises chip select and starts an access on the same edge. As a result, each acknowledge window, release edge and abandonment point falls on a well-defined rising edge that the reference model can follow cycle by cycle.

// File: rtl/ubus_pkg.sv
package ubus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } ubus_state_e;
endpackage

// File: rtl/ubus_regbank.sv
module ubus_regbank #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (wr_i && waddr_i == AW'(g))            regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/ubus_ctrl.sv
module ubus_ctrl
  import ubus_pkg::*;
#(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int LAT_RD    = 2,
  parameter int LAT_SLOW  = 3,
  parameter int LAT_WR    = 3,
  parameter int SLOW_ADDR = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ds_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_stb_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          dtack_no
);
  localparam int MAXLAT = (LAT_RD > LAT_SLOW) ?
                          ((LAT_RD > LAT_WR) ? LAT_RD : LAT_WR) :
                          ((LAT_SLOW > LAT_WR) ? LAT_SLOW : LAT_WR);
  localparam int CW = (MAXLAT < 2) ? 1 : $clog2(MAXLAT);

  ubus_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_load;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic          rd_q;
  logic          start;

  assign start = (state_q == ST_IDLE) && !cs_ni && !ds_ni;

  always_comb begin
    if (!rw_i)                          cnt_load = CW'(LAT_WR - 1);
    else if (addr_i == AW'(SLOW_ADDR))  cnt_load = CW'(LAT_SLOW - 1);
    else                                cnt_load = CW'(LAT_RD - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      addr_q    <= '0;
      wdat_q    <= '0;
      rd_q      <= 1'b0;
      wr_stb_o  <= 1'b0;
      dtack_no  <= 1'b1;
      data_oe_o <= 1'b0;
      data_o    <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= addr_i;
            wdat_q  <= data_i;
            rd_q    <= rw_i;
            cnt_q   <= cnt_load;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cs_ni) begin
            state_q <= ST_IDLE;          // abandoned before acknowledge
          end else if (cnt_q == '0) begin
            state_q  <= ST_ACK;
            dtack_no <= 1'b0;
            if (rd_q) begin
              data_o    <= rd_data_i;
              data_oe_o <= 1'b1;
            end else begin
              wr_stb_o <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ACK: begin
          if (cs_ni) begin
            state_q   <= ST_IDLE;
            dtack_no  <= 1'b1;
            data_oe_o <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o    = addr_q;
  assign wr_data_o = wdat_q;

  // R5: acknowledge held while selected, released when deselected
  p_dtack_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && !cs_ni) |=> !dtack_no);
  p_dtack_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && cs_ni) |=> dtack_no);
  // R4: one strobe, coincident with the acknowledge falling
  p_wr_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);
  p_wr_on_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (!dtack_no && $past(dtack_no)));
  // R8: bus driven by the time acknowledge falls on a read, released on deselect
  p_oe_at_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dtack_no) && rd_q) |-> data_oe_o);
  p_oe_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && cs_ni) |=> !data_oe_o);
  // R7: deselect before acknowledge returns to idle without acknowledge
  p_abandon_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && cs_ni) |=> (dtack_no && !wr_stb_o && state_q == ST_IDLE));
endmodule

// File: rtl/ubus_slave.sv
module ubus_slave #(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int LAT_RD    = 2,
  parameter int LAT_SLOW  = 3,
  parameter int LAT_WR    = 3,
  parameter int SLOW_ADDR = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ds_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          dtack_no
);
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdat;
  logic [DW-1:0] bank_rdat;
  logic          bank_wr;

  ubus_ctrl #(
    .AW(AW), .DW(DW), .LAT_RD(LAT_RD), .LAT_SLOW(LAT_SLOW),
    .LAT_WR(LAT_WR), .SLOW_ADDR(SLOW_ADDR)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .ds_ni     (ds_ni),
    .rw_i      (rw_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .rd_data_i (bank_rdat),
    .addr_o    (acc_addr),
    .wr_data_o (acc_wdat),
    .wr_stb_o  (bank_wr),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .dtack_no  (dtack_no)
  );

  ubus_regbank #(.AW(AW), .DW(DW)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bank_wr),
    .waddr_i (acc_addr),
    .wdata_i (acc_wdat),
    .raddr_i (acc_addr),
    .rdata_o (bank_rdat)
  );
endmodule

// File: tb/test_ubus_slave.sv
module test_ubus_slave;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, ds_ni = 1'b1, rw_i = 1'b1;
  logic [2:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       data_oe_o, dtack_no;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  ubus_slave i_ubus_slave (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .ds_ni(ds_ni), .rw_i(rw_i),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .dtack_no(dtack_no)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 idle, 1 waiting, 2 acknowledged
  int         m_st = 0, m_cnt = 0;
  bit         m_rd = 0;
  logic [2:0] m_addr = '0;
  logic [7:0] m_wdat = '0;
  logic       m_dtack = 1'b1, m_oe = 1'b0;
  logic [7:0] m_data = '0;
  logic [7:0] m_regs [8];

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_st = 0; m_dtack = 1'b1; m_oe = 1'b0;
      for (int i = 0; i < 8; i++) m_regs[i] = '0;
    end else begin
      case (m_st)
        0: if (!cs_ni && !ds_ni) begin
             m_rd = rw_i; m_addr = addr_i; m_wdat = data_i;
             m_cnt = (!rw_i) ? 3 : (addr_i == 3'd0 ? 3 : 2);
             m_st = 1;
           end
        1: if (cs_ni) m_st = 0;
           else begin
             m_cnt--;
             if (m_cnt == 0) begin
               m_st = 2; m_dtack = 1'b0;
               if (m_rd) begin m_oe = 1'b1; m_data = m_regs[m_addr]; end
               else m_regs[m_addr] = m_wdat;
             end
           end
        default: if (cs_ni) begin m_st = 0; m_dtack = 1'b1; m_oe = 1'b0; end
      endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_ni) begin
      check(dtack_no === m_dtack, "R5 model dtack", dtack_no, m_dtack);
      check(data_oe_o === m_oe, "R8 model oe", data_oe_o, m_oe);
      if (m_oe) check(data_o === m_data, "R8 model data", data_o, m_data);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // one framed access; ds_ni/rw_i left at their levels afterwards
  task automatic access(input bit rd, input logic [2:0] a, input logic [7:0] d,
                        input int exp_lat, input logic [7:0] exp_rd, input string req,
                        input bit corrupt_data);
    int n = 0;
    bit got = 0;
    @(negedge clk);
    cs_ni = 1'b0; ds_ni = 1'b0; rw_i = rd; addr_i = a; data_i = d;
    while (n < 8 && !got) begin
      @(negedge clk);
      n++;
      if (corrupt_data && n == 1) data_i = ~d;   // R10: change after capture
      if (!dtack_no) got = 1;
    end
    check(got && (n - 1) == exp_lat, req, n - 1, exp_lat);
    if (rd) check(data_oe_o && data_o === exp_rd, {req, " R8 read data"}, data_o, exp_rd);
    cs_ni = 1'b1;
    @(negedge clk);
    check(dtack_no === 1'b1, {req, " R5 release"}, dtack_no, 1);
    check(data_oe_o === 1'b0, {req, " R8 bus release"}, data_oe_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dtack_no === 1'b1, "R1 reset dtack", dtack_no, 1);
    check(data_oe_o === 1'b0, "R1 reset oe", data_oe_o, 0);
    rst_ni = 1'b1;

    access(1, 3'd5, 8'h00, 2, 8'h00, "R1 R2 read reset value", 0);
    access(1, 3'd0, 8'h00, 3, 8'h00, "R3 read addr0", 0);
    access(0, 3'd6, 8'hA5, 3, 8'h00, "R4 write addr6", 0);
    access(0, 3'd0, 8'h5A, 3, 8'h00, "R4 R9 back-to-back write addr0", 0);
    access(1, 3'd6, 8'h00, 2, 8'hA5, "R11 readback addr6", 0);
    access(1, 3'd0, 8'h00, 3, 8'h5A, "R3 R11 readback addr0", 0);

    // R6: continued read, ds/rw held, only cs toggles
    access(1, 3'd6, 8'h00, 2, 8'hA5, "R6 continued read 1", 0);
    access(1, 3'd0, 8'h00, 3, 8'h5A, "R6 continued read 2", 0);
    check(ds_ni === 1'b0 && rw_i === 1'b1, "R6 strobes held", ds_ni, 0);

    // R10: data changed after start edge
    access(0, 3'd3, 8'h3C, 3, 8'h00, "R10 write capture", 1);
    access(1, 3'd3, 8'h00, 2, 8'h3C, "R10 captured value", 0);

    // R7: abandon a write after one cycle
    @(negedge clk);
    cs_ni = 1'b0; ds_ni = 1'b0; rw_i = 1'b0; addr_i = 3'd3; data_i = 8'hEE;
    @(negedge clk);
    cs_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(dtack_no === 1'b1, "R7 no acknowledge", dtack_no, 1);
    end
    access(1, 3'd3, 8'h00, 2, 8'h3C, "R7 register unchanged", 0);

    // R5: dtack held for extra cycles while cs stays low
    @(negedge clk);
    cs_ni = 1'b0; ds_ni = 1'b0; rw_i = 1'b1; addr_i = 3'd2;
    repeat (8) @(negedge clk);
    check(dtack_no === 1'b0, "R5 hold low", dtack_no, 0);
    cs_ni = 1'b1;
    @(negedge clk);
    check(dtack_no === 1'b1, "R5 release with ds low", dtack_no, 1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule